// File: doc/BRIEF.md
# Programmable Clock Divider Chain and Output Selector

This block holds the digital part of one synthesized clock output. A fixed reference divider and a programmable feedback divider each send a narrow pulse per period to an external phase detector. The post-divider derives the output clock from the oscillator clock. An output selector then chooses between that divided clock and an external clock input. The settings come from one frequency-table entry: an 8-bit feedback field, a 2-bit post-divide code and an external-select flag.

One combination of the entry requests a loop power-down: the external flag set together with a post-divide code of 11. In that state the feedback and post dividers are frozen. The external clock still reaches the output, and the reference divider keeps counting. A new feedback setting takes effect only when the feedback count wraps. A new post-divide code takes effect only when the post counter wraps. This keeps partial periods off both paths.

Top module: `synth_div_select`

## Requirements
- R1: The feedback divider output `fb_div_out` is high for one `vco_clk` cycle every N+257 `vco_clk` cycles, where N is `n_sel` read as unsigned (modulus 257 to 512).
- R2: The reference divider output `ref_div_out` is high for one `ref_clk` cycle every 43 `ref_clk` cycles.
- R3: With `ext_sel`=0, `div_sel` sets the output ratio as follows: 00 divides `vco_clk` by 8, 01 by 4, 10 by 2, and 11 passes `vco_clk` through (divide by 1).
- R4: With `ext_sel`=1, `clk_out` follows `ext_clk`, and the feedback divider keeps counting.
- R5: When `ext_sel`=1 and `div_sel`=11, `pll_pd` is 1. The feedback divider is then frozen with `fb_div_out` low, and `clk_out` still follows `ext_clk`.
- R6: The reference divider keeps its 43-cycle period while `pll_pd` is 1.
- R7: With N=18 and `div_sel`=10, the feedback period is 275 `vco_clk` cycles, and `clk_out` toggles at half the `vco_clk` rate.
- R8: For the divide-by-2, 4 and 8 codes, `clk_out` is high and low for equal numbers of `vco_clk` cycles.
- R9: A change of `n_sel` during a feedback period does not alter that period. It sets the length of the next one. A change of `div_sel` takes effect only when the 3-bit post counter wraps.
- R10: An active-low asynchronous `rst_n` clears all counters. While it is low, `clk_out` is low (with `ext_sel`=0) and `ref_div_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of all counters |
| ref_clk | input | 1 | Reference oscillator clock |
| vco_clk | input | 1 | Oscillator clock from the loop |
| ext_clk | input | 1 | External clock that can replace the synthesized output |
| n_sel | input | 8 | Feedback field N (modulus N+257) |
| div_sel | input | 2 | Post-divide code |
| ext_sel | input | 1 | External-select flag of the table entry |
| ref_div_out | output | 1 | Reference divider pulse to the phase detector |
| fb_div_out | output | 1 | Feedback divider pulse to the phase detector |
| clk_out | output | 1 | Selected output clock |
| pll_pd | output | 1 | Loop power-down request |

## Verification
A wrong feedback reload value shows up as a wrong pulse spacing on `fb_div_out`. It is visible within one full period, which is at most 512 oscillator cycles after the first pulse. A post counter or latched code that is out of step shows up on `clk_out` within one output period, at most eight oscillator cycles: the high and low runs become unequal or have the wrong length. A power-down decode error appears at once: either `fb_div_out` pulses while `pll_pd` is high, or `pll_pd` stays low when the entry requests shutdown. A setting applied too early lengthens or shortens the period that is already running, and the bench measures exactly that period.

// File: rtl/synth_div_select.sv
module synth_div_select #(
  parameter int REF_MOD = 43,
  parameter int N_W     = 8,
  parameter int FB_BASE = 257
) (
  input  logic           rst_n,
  input  logic           ref_clk,
  input  logic           vco_clk,
  input  logic           ext_clk,
  input  logic [N_W-1:0] n_sel,
  input  logic [1:0]     div_sel,
  input  logic           ext_sel,
  output logic           ref_div_out,
  output logic           fb_div_out,
  output logic           clk_out,
  output logic           pll_pd
);
  localparam int REF_W  = $clog2(REF_MOD);
  localparam int FB_MAX = FB_BASE + (1 << N_W) - 1;
  localparam int FB_W   = $clog2(FB_MAX);

  logic [REF_W-1:0] ref_cnt;
  logic [FB_W-1:0]  fb_cnt;
  logic [FB_W-1:0]  fb_reload;
  logic [2:0]       post_cnt;
  logic [1:0]       div_q;
  logic             post_clk;

  assign pll_pd    = ext_sel & (&div_sel);
  assign fb_reload = FB_W'(FB_BASE - 1) + FB_W'(n_sel);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)              ref_cnt <= '0;
    else if (ref_cnt == '0)  ref_cnt <= REF_W'(REF_MOD - 1);
    else                     ref_cnt <= ref_cnt - 1'b1;
  end

  assign ref_div_out = (ref_cnt == '0);

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n)             fb_cnt <= '0;
    else if (pll_pd)        fb_cnt <= '0;
    else if (fb_cnt == '0)  fb_cnt <= fb_reload;
    else                    fb_cnt <= fb_cnt - 1'b1;
  end

  assign fb_div_out = !pll_pd && (fb_cnt == '0);

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      post_cnt <= '0;
      div_q    <= '0;
    end else if (pll_pd) begin
      post_cnt <= '0;
      div_q    <= div_sel;
    end else begin
      post_cnt <= post_cnt + 1'b1;
      if (&post_cnt) div_q <= div_sel;
    end
  end

  always_comb begin
    case (div_q)
      2'b00:   post_clk = post_cnt[2];
      2'b01:   post_clk = post_cnt[1];
      2'b10:   post_clk = post_cnt[0];
      default: post_clk = vco_clk;
    endcase
  end

  assign clk_out = ext_sel ? ext_clk : post_clk;
endmodule

// File: rtl/synth_div_select_chk.sv
module synth_div_select_chk #(
  parameter int REF_MOD = 43
) (
  input logic rst_n,
  input logic ref_clk,
  input logic vco_clk,
  input logic ext_clk,
  input logic ext_sel,
  input logic ref_div_out,
  input logic fb_div_out,
  input logic clk_out,
  input logic pll_pd
);
  logic [7:0] gap;
  logic       seen;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (ref_div_out) begin
      if (seen) begin
        AST_REF_GAP: assert (gap == 8'(REF_MOD - 1)) else $error("reference pulse spacing wrong"); // R2
      end
      seen <= 1'b1;
      gap  <= '0;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  AST_FB_SINGLE: assert property (@(posedge vco_clk) disable iff (!rst_n) fb_div_out |=> !fb_div_out) else $error("feedback pulse too wide"); // R1
  AST_REF_SINGLE: assert property (@(posedge ref_clk) disable iff (!rst_n) ref_div_out |=> !ref_div_out) else $error("reference pulse too wide"); // R2
  AST_EXT_PASS: assert property (@(posedge ref_clk) disable iff (!rst_n) ext_sel |-> (clk_out == ext_clk)) else $error("external clock not selected"); // R4
  AST_PD_FB_QUIET: assert property (@(posedge ref_clk) disable iff (!rst_n) pll_pd |-> !fb_div_out) else $error("feedback active in power-down"); // R5
endmodule

bind synth_div_select synth_div_select_chk #(.REF_MOD(REF_MOD)) u_chk (
  .rst_n(rst_n), .ref_clk(ref_clk), .vco_clk(vco_clk), .ext_clk(ext_clk),
  .ext_sel(ext_sel), .ref_div_out(ref_div_out), .fb_div_out(fb_div_out),
  .clk_out(clk_out), .pll_pd(pll_pd)
);

// File: tb/tb_synth_div_select.sv
module tb_synth_div_select;
  localparam int CLK_PERIOD = 10;
  localparam int VCO_P = 4;
  localparam int EXT_P = 14;
  localparam int K_FB = 0, K_REF = 1, K_DUTY = 2, K_VEDGE = 3, K_XEDGE = 4,
                 K_FBQUIET = 5, K_FBCHG = 6, K_LVL = 7;

  logic rst_n = 1'b0, ref_clk = 1'b0, vco_clk = 1'b0, ext_clk = 1'b0;
  logic [7:0] n_sel = '0;
  logic [1:0] div_sel = '0;
  logic ext_sel = 1'b0;
  logic ref_div_out, fb_div_out, clk_out, pll_pd;

  int nchk = 0, nerr = 0, pending = 0, edge_cnt = 0;
  logic cnt_en = 1'b0;

  typedef struct { int kind; int exp; int aux; string req; } item_t;
  item_t q[$];

  synth_div_select dut (
    .rst_n(rst_n), .ref_clk(ref_clk), .vco_clk(vco_clk), .ext_clk(ext_clk),
    .n_sel(n_sel), .div_sel(div_sel), .ext_sel(ext_sel),
    .ref_div_out(ref_div_out), .fb_div_out(fb_div_out), .clk_out(clk_out), .pll_pd(pll_pd)
  );

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;
  always #(VCO_P/2) vco_clk = ~vco_clk;
  always #(EXT_P/2) ext_clk = ~ext_clk;
  always @(posedge clk_out) if (cnt_en) edge_cnt++;

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(int kind, int exp, int aux, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.aux = aux; it.req = req;
    pending++;
    q.push_back(it);
    wait (pending == 0);
  endtask

  task automatic set_cfg(int n, int d, bit e);
    @(negedge ref_clk);
    n_sel = 8'(n); div_sel = 2'(d); ext_sel = e;
    repeat (10) @(negedge ref_clk);
  endtask

  task automatic fb_period(output int c);
    do @(negedge vco_clk); while (!fb_div_out);
    c = 0;
    do begin @(negedge vco_clk); c++; end while (!fb_div_out);
  endtask

  initial begin : monitor
    item_t it;
    int c, h, l;
    forever begin
      wait (q.size() > 0);
      it = q[0];
      case (it.kind)
        K_FB: begin fb_period(c); chk(it.req, c, it.exp); end
        K_REF: begin
          do @(negedge ref_clk); while (!ref_div_out);
          c = 0;
          do begin @(negedge ref_clk); c++; end while (!ref_div_out);
          chk(it.req, c, it.exp);
        end
        K_DUTY: begin
          do @(negedge vco_clk); while (clk_out);
          do @(negedge vco_clk); while (!clk_out);
          h = 0; l = 0;
          do begin h++; @(negedge vco_clk); end while (clk_out);
          do begin l++; @(negedge vco_clk); end while (!clk_out);
          chk({it.req, " high"}, h, it.exp);
          chk({it.req, " low"}, l, it.exp);
        end
        K_VEDGE: begin
          @(negedge vco_clk); edge_cnt = 0; cnt_en = 1'b1;
          #(it.aux); cnt_en = 1'b0;
          chk(it.req, edge_cnt, it.exp);
        end
        K_XEDGE: begin
          @(negedge ext_clk); edge_cnt = 0; cnt_en = 1'b1;
          #(it.aux); cnt_en = 1'b0;
          chk(it.req, edge_cnt, it.exp);
        end
        K_FBQUIET: begin
          c = 0;
          for (int i = 0; i < it.aux; i++) begin @(negedge vco_clk); if (fb_div_out) c++; end
          chk(it.req, c, it.exp);
        end
        K_FBCHG: begin
          do @(negedge vco_clk); while (!fb_div_out);
          c = 0;
          repeat (10) begin @(negedge vco_clk); c++; end
          n_sel = 8'(it.aux);
          while (!fb_div_out) begin @(negedge vco_clk); c++; end
          chk({it.req, " running period"}, c, it.exp);
          c = 0;
          do begin @(negedge vco_clk); c++; end while (!fb_div_out);
          chk({it.req, " next period"}, c, 257 + it.aux);
        end
        default: begin
          @(negedge ref_clk);
          c = (it.aux == 0) ? int'(clk_out) : (it.aux == 1) ? int'(ref_div_out) : int'(pll_pd);
          chk(it.req, c, it.exp);
        end
      endcase
      void'(q.pop_front());
      pending--;
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin : driver
    repeat (5) @(negedge ref_clk);
    push(K_LVL, 0, 0, "R10 clk_out low in reset");
    push(K_LVL, 1, 1, "R10 reference counter cleared in reset");
    @(negedge ref_clk); rst_n = 1'b1;
    push(K_REF, 43, 0, "R2 reference period");
    set_cfg(0, 0, 1'b0);
    push(K_FB, 257, 0, "R1 feedback period N=0");
    push(K_DUTY, 4, 0, "R3 R8 divide by 8");
    set_cfg(255, 1, 1'b0);
    push(K_FB, 512, 0, "R1 feedback period N=255");
    push(K_DUTY, 2, 0, "R3 R8 divide by 4");
    set_cfg(255, 3, 1'b0);
    push(K_VEDGE, 20, 20 * VCO_P, "R3 divide by 1 edges");
    set_cfg(0, 3, 1'b0);
    push(K_FBCHG, 257, 100, "R9 feedback setting change");
    set_cfg(100, 0, 1'b1);
    push(K_XEDGE, 10, 10 * EXT_P, "R4 external clock edges");
    push(K_FB, 357, 0, "R4 feedback still counting");
    set_cfg(100, 3, 1'b1);
    push(K_LVL, 1, 2, "R5 power-down request");
    push(K_FBQUIET, 0, 600, "R5 feedback frozen");
    push(K_XEDGE, 10, 10 * EXT_P, "R5 external clock in power-down");
    push(K_REF, 43, 0, "R6 reference period in power-down");
    set_cfg(18, 2, 1'b0);
    push(K_LVL, 0, 2, "R5 power-down released");
    push(K_FB, 275, 0, "R7 feedback period N=18");
    push(K_DUTY, 1, 0, "R7 R8 divide by 2");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule